// File: doc/BRIEF.md
# Expansion Bus Slave Interface

This block is the slave end of a 16-bit, 68000-style asynchronous expansion bus. It runs on a local clock and passes every bus input through a two-stage synchronizer. It decodes an address window that a parameter sets. The address strobe tells it when a bus cycle starts and ends, and the two data strobes tell it when write data is valid and which byte lanes are in use. Each bus access it accepts becomes one request on a simple local port (word offset, byte enables, write data, direction). That request is held until the local side returns a ready pulse.

Wait states come from one of two methods, chosen by a parameter. In the first, the slave pulls the shared ready line low early in the cycle and lets it go once local data is ready. In the second, the slave asserts the override line for the whole cycle and drives its own acknowledge. All three handshake outputs are open-collector: each is a drive-low enable plus a value output tied to 0. When the address strobe rises, every drive enable and the read-data enable drop in that same cycle.

A locked read-modify-write keeps the address strobe low across more than one data-strobe burst. The block treats each burst as a separate access.

Top module: `xbus_slave`

## Requirements
- R1: While reset is high, and in the first cycle after it, `ack_drv`, `rdy_drv`, `ovr_drv`, `bus_doe` and `loc_req` are all 0, whatever the bus inputs are.
- R2: An access is taken only when byte address bits [ADDR_W-1:WIN_BITS] equal the same bits of `BASE_ADDR`. Outside the window the block raises no local request and drives no handshake output or data enable.
- R3: Each accepted access raises `loc_req` with `loc_addr` = byte address bits [WIN_BITS-1:1], `loc_we` = 1 when `bus_rd` is 0, and `loc_wdata` = the bus write data. All of these stay stable until `loc_ready` is sampled high.
- R4: `loc_be[0]` is the lower strobe and selects data bits 7:0. `loc_be[1]` is the upper strobe and selects bits 15:8. A byte write leaves the other byte unchanged.
- R5: `bus_doe` is high only during a read that hit the window, after the local data has returned, while a data strobe is asserted. `bus_rdata` then carries the returned word. `bus_doe` stays 0 for writes.
- R6: With OWN_ACK = 0, `rdy_drv` is asserted once the synchronized address strobe shows a hit. It stays asserted for as long as the local request is pending and drops once the data has returned. `ack_drv` and `ovr_drv` stay 0.
- R7: With OWN_ACK = 1, `ovr_drv` is held for the whole hit cycle. `ack_drv` rises only after local data has returned and falls once the data strobes are negated. `rdy_drv` stays 0.
- R8: When `bus_as_n` is high, `ack_drv`, `rdy_drv`, `ovr_drv` and `bus_doe` are 0 in the same cycle, with no synchronizer delay.
- R9: While the address strobe stays low, the data strobes going from all negated to any asserted starts a new access. That access uses its own direction, byte enables and data.
- R10: Data strobes held asserted start only one access. No second request is raised until the strobes have been negated.
- R11: `ack_val`, `rdy_val` and `ovr_val` are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_uds_n | input | 1 | Upper byte strobe (bits 15:8), active low |
| bus_lds_n | input | 1 | Lower byte strobe (bits 7:0), active low |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_addr | input | ADDR_W-1 | Word address, byte address bits [ADDR_W-1:1] |
| bus_wdata | input | 16 | Write data from the bus |
| bus_rdata | output | 16 | Read data to the bus |
| bus_doe | output | 1 | Read data output enable |
| ack_drv | output | 1 | Own acknowledge drive-low enable |
| ack_val | output | 1 | Acknowledge driven value, always 0 |
| rdy_drv | output | 1 | Ready line drive-low enable (adds wait states) |
| rdy_val | output | 1 | Ready driven value, always 0 |
| ovr_drv | output | 1 | Override drive-low enable |
| ovr_val | output | 1 | Override driven value, always 0 |
| loc_req | output | 1 | Local access pending |
| loc_we | output | 1 | Local access is a write |
| loc_addr | output | WIN_BITS-1 | Word offset inside the window |
| loc_be | output | 2 | Byte enables, bit 0 = bits 7:0 |
| loc_wdata | output | 16 | Local write data |
| loc_rdata | input | 16 | Local read data, valid with loc_ready |
| loc_ready | input | 1 | Local access complete |

## Verification
The bench targets the locked read-modify-write. A design that starts accesses on the address strobe alone would miss the write burst. A design that does not wait for the strobes to be negated would issue repeated requests while the strobes are held. The bench also probes the words at both edges of the window and the first word above it. An off-by-one in the window compare would either miss the top word or corrupt word zero through an aliased write. Byte-lane writes followed by read-back catch swapped strobes. Reads and writes run on a ready-line instance and an override instance side by side. This catches a ready line released before the data returns, an own acknowledge raised too early, and outputs that are still driven after the address strobe rises.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int XB_DW = 16;
    localparam int XB_BE = XB_DW / 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_HOLD   = 2'd2
    } xs_state_e;

    typedef struct packed {
        logic as_n;
        logic uds_n;
        logic lds_n;
        logic rd;
    } bus_ctl_t;

    localparam int CTL_W = $bits(bus_ctl_t);
    localparam logic [CTL_W-1:0] CTL_IDLE = 4'b1110;

    typedef struct packed {
        logic             we;
        logic [XB_BE-1:0] be;
        logic [XB_DW-1:0] wdata;
    } acc_t;

    function automatic logic strobes_any(input bus_ctl_t c);
        return !c.uds_n || !c.lds_n;
    endfunction

    function automatic logic [XB_BE-1:0] strobe_be(input bus_ctl_t c);
        return {!c.uds_n, !c.lds_n};
    endfunction

endpackage

// File: rtl/xbus_sync.sv
module xbus_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/xbus_window.sv
module xbus_window #(
    parameter int                ADDR_W    = 24,
    parameter int                WIN_BITS  = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h200000
) (
    input  logic [ADDR_W-1:1]   addr,
    output logic                hit,
    output logic [WIN_BITS-2:0] ofs
);

    localparam int TAG_W = ADDR_W - WIN_BITS;
    localparam logic [TAG_W-1:0] BASE_TAG = BASE_ADDR[ADDR_W-1:WIN_BITS];

    assign hit = (addr[ADDR_W-1:WIN_BITS] == BASE_TAG);
    assign ofs = addr[WIN_BITS-1:1];

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int OFS_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_ctl_t         ctl,
    input  logic             hit,
    input  logic [OFS_W-1:0] ofs,
    input  logic [XB_DW-1:0] wdata,
    input  logic             loc_ready,
    input  logic [XB_DW-1:0] loc_rdata,
    output xs_state_e        state,
    output acc_t             acc,
    output logic [OFS_W-1:0] acc_addr,
    output logic [XB_DW-1:0] rdata
);

    logic start;
    logic burst_end;

    // a fresh access needs an idle state, a low strobe and any data strobe
    assign start     = (state == ST_IDLE) && !ctl.as_n && strobes_any(ctl) && hit;
    assign burst_end = ctl.as_n || !strobes_any(ctl);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            acc      <= '0;
            acc_addr <= '0;
            rdata    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state     <= ST_ACCESS;
                        acc.we    <= !ctl.rd;
                        acc.be    <= strobe_be(ctl);
                        acc.wdata <= wdata;
                        acc_addr  <= ofs;
                    end
                end
                ST_ACCESS: begin
                    if (loc_ready) begin
                        rdata <= loc_rdata;
                        state <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    // back to idle only after the strobes drop, so a held
                    // strobe never issues a second request
                    if (burst_end) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xbus_slave.sv
module xbus_slave
    import xbus_pkg::*;
#(
    parameter int                ADDR_W    = 24,
    parameter int                WIN_BITS  = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h200000,
    parameter bit                OWN_ACK   = 1'b0,
    parameter int                SYNC_STG  = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_as_n,
    input  logic                  bus_uds_n,
    input  logic                  bus_lds_n,
    input  logic                  bus_rd,
    input  logic [ADDR_W-1:1]     bus_addr,
    input  logic [15:0]           bus_wdata,
    output logic [15:0]           bus_rdata,
    output logic                  bus_doe,
    output logic                  ack_drv,
    output logic                  ack_val,
    output logic                  rdy_drv,
    output logic                  rdy_val,
    output logic                  ovr_drv,
    output logic                  ovr_val,
    output logic                  loc_req,
    output logic                  loc_we,
    output logic [WIN_BITS-2:0]   loc_addr,
    output logic [1:0]            loc_be,
    output logic [15:0]           loc_wdata,
    input  logic [15:0]           loc_rdata,
    input  logic                  loc_ready
);

    localparam int OFS_W = WIN_BITS - 1;
    localparam int AW    = ADDR_W - 1;

    bus_ctl_t          ctl_raw;
    bus_ctl_t          ctl_s;
    logic [CTL_W-1:0]  ctl_q;
    logic [AW-1:0]     addr_s;
    logic [XB_DW-1:0]  wdata_s;
    logic              hit;
    logic [OFS_W-1:0]  ofs;
    xs_state_e         st;
    acc_t              acc;
    logic [OFS_W-1:0]  acc_addr;
    logic [XB_DW-1:0]  rdata_q;
    logic              live;
    logic              hit_now;

    assign ctl_raw = '{as_n: bus_as_n, uds_n: bus_uds_n, lds_n: bus_lds_n, rd: bus_rd};

    xbus_sync #(.W(CTL_W), .STAGES(SYNC_STG), .RST_VAL(CTL_IDLE)) u_sync_ctl (
        .clk (clk),
        .rst (rst),
        .d   (ctl_raw),
        .q   (ctl_q)
    );
    assign ctl_s = bus_ctl_t'(ctl_q);

    xbus_sync #(.W(AW), .STAGES(SYNC_STG), .RST_VAL('0)) u_sync_addr (
        .clk (clk),
        .rst (rst),
        .d   (bus_addr),
        .q   (addr_s)
    );

    xbus_sync #(.W(XB_DW), .STAGES(SYNC_STG), .RST_VAL('0)) u_sync_data (
        .clk (clk),
        .rst (rst),
        .d   (bus_wdata),
        .q   (wdata_s)
    );

    xbus_window #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .BASE_ADDR(BASE_ADDR)) u_win (
        .addr (addr_s),
        .hit  (hit),
        .ofs  (ofs)
    );

    xbus_ctrl #(.OFS_W(OFS_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl_s),
        .hit       (hit),
        .ofs       (ofs),
        .wdata     (wdata_s),
        .loc_ready (loc_ready),
        .loc_rdata (loc_rdata),
        .state     (st),
        .acc       (acc),
        .acc_addr  (acc_addr),
        .rdata     (rdata_q)
    );

    // raw strobe gates every bus-side output: release is immediate
    assign live    = !bus_as_n;
    assign hit_now = hit && !ctl_s.as_n;

    assign loc_req   = (st == ST_ACCESS);
    assign loc_we    = acc.we;
    assign loc_be    = acc.be;
    assign loc_wdata = acc.wdata;
    assign loc_addr  = acc_addr;

    assign bus_rdata = rdata_q;
    assign bus_doe   = live && (st == ST_HOLD) && !acc.we && strobes_any(ctl_s);

    assign ack_val = 1'b0;
    assign rdy_val = 1'b0;
    assign ovr_val = 1'b0;

    generate
        if (OWN_ACK) begin : g_own_ack
            assign ovr_drv = live && (hit_now || st != ST_IDLE);
            assign ack_drv = live && (st == ST_HOLD) && strobes_any(ctl_s);
            assign rdy_drv = 1'b0;
        end else begin : g_ready_line
            assign rdy_drv = live && ((st == ST_IDLE && hit_now) || st == ST_ACCESS);
            assign ack_drv = 1'b0;
            assign ovr_drv = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/xbus_slave_chk.sv
module xbus_slave_chk #(
    parameter bit OWN_ACK = 1'b0,
    parameter int OFS_W   = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_as_n,
    input logic             bus_doe,
    input logic             ack_drv,
    input logic             rdy_drv,
    input logic             ovr_drv,
    input logic             loc_req,
    input logic             loc_ready,
    input logic             loc_we,
    input logic [OFS_W-1:0] loc_addr,
    input logic [1:0]       loc_be,
    input logic [15:0]      loc_wdata
);

    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        bus_as_n |-> !(ack_drv || rdy_drv || ovr_drv || bus_doe));

    p_req_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (loc_req && !loc_ready) |=> (loc_req && $stable(loc_addr) && $stable(loc_be)
                                     && $stable(loc_we) && $stable(loc_wdata)));

    p_doe_read_r5: assert property (@(posedge clk) disable iff (rst)
        bus_doe |-> (!loc_we && !loc_req));

    p_rdy_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!OWN_ACK && $fell(rdy_drv) && !bus_as_n) |-> $past(loc_req && loc_ready));

    p_ack_after_data_r7: assert property (@(posedge clk) disable iff (rst)
        (OWN_ACK && $rose(ack_drv)) |-> $past(loc_req && loc_ready));

    p_ack_not_early_r7: assert property (@(posedge clk) disable iff (rst)
        (OWN_ACK && loc_req) |-> !ack_drv);

endmodule

bind xbus_slave xbus_slave_chk #(.OWN_ACK(OWN_ACK), .OFS_W(WIN_BITS - 1)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_as_n  (bus_as_n),
    .bus_doe   (bus_doe),
    .ack_drv   (ack_drv),
    .rdy_drv   (rdy_drv),
    .ovr_drv   (ovr_drv),
    .loc_req   (loc_req),
    .loc_ready (loc_ready),
    .loc_we    (loc_we),
    .loc_addr  (loc_addr),
    .loc_be    (loc_be),
    .loc_wdata (loc_wdata)
);

// File: tb/sim_xbus_slave.sv
module sim_xbus_slave;

    localparam int LAT = 3;

    typedef struct packed {
        logic        rd;
        logic [1:0]  be;
        logic [23:0] addr;
        logic [15:0] wd;
        logic        hit;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'b11, 24'h200010, 16'h1234, 1'b1, 16'h0000},
        '{1'b1, 2'b11, 24'h200010, 16'h0000, 1'b1, 16'h1234},
        '{1'b0, 2'b01, 24'h200010, 16'hAAEE, 1'b1, 16'h0000},
        '{1'b1, 2'b11, 24'h200010, 16'h0000, 1'b1, 16'h12EE},
        '{1'b0, 2'b10, 24'h200010, 16'h55FF, 1'b1, 16'h0000},
        '{1'b1, 2'b11, 24'h200010, 16'h0000, 1'b1, 16'h55EE},
        '{1'b0, 2'b11, 24'h2000FE, 16'hBEEF, 1'b1, 16'h0000},
        '{1'b1, 2'b11, 24'h2000FE, 16'h0000, 1'b1, 16'hBEEF},
        '{1'b0, 2'b11, 24'h200100, 16'hDEAD, 1'b0, 16'h0000},
        '{1'b1, 2'b11, 24'h1FFFFE, 16'h0000, 1'b0, 16'h0000},
        '{1'b1, 2'b01, 24'h200000, 16'h0000, 1'b1, 16'h0000},
        '{1'b1, 2'b11, 24'h2000FE, 16'h0000, 1'b1, 16'hBEEF}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_as_n = 1'b1;
    logic [1:0]  ds_n = 2'b11;
    logic        bus_rd = 1'b1;
    logic [23:1] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] loc_rdata = '0;
    logic        loc_ready = 1'b0;

    logic [15:0] rdata0, rdata1, wd0, wd1;
    logic        doe0, doe1, ack0, ack1, rdy0, rdy1, ovr0, ovr1;
    logic        av0, av1, rv0, rv1, ov0, ov1;
    logic        req0, req1, we0, we1;
    logic [6:0]  la0, la1;
    logic [1:0]  be0, be1;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    xbus_slave #(.OWN_ACK(1'b0)) u0 (
        .clk(clk), .rst(rst), .bus_as_n(bus_as_n), .bus_uds_n(ds_n[1]), .bus_lds_n(ds_n[0]),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata0), .bus_doe(doe0), .ack_drv(ack0), .ack_val(av0),
        .rdy_drv(rdy0), .rdy_val(rv0), .ovr_drv(ovr0), .ovr_val(ov0),
        .loc_req(req0), .loc_we(we0), .loc_addr(la0), .loc_be(be0), .loc_wdata(wd0),
        .loc_rdata(loc_rdata), .loc_ready(loc_ready)
    );

    xbus_slave #(.OWN_ACK(1'b1)) u1 (
        .clk(clk), .rst(rst), .bus_as_n(bus_as_n), .bus_uds_n(ds_n[1]), .bus_lds_n(ds_n[0]),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata1), .bus_doe(doe1), .ack_drv(ack1), .ack_val(av1),
        .rdy_drv(rdy1), .rdy_val(rv1), .ovr_drv(ovr1), .ovr_val(ov1),
        .loc_req(req1), .loc_we(we1), .loc_addr(la1), .loc_be(be1), .loc_wdata(wd1),
        .loc_rdata(loc_rdata), .loc_ready(loc_ready)
    );

    // local register file model plus observation counters
    logic [15:0] mem [128];
    int          req_cnt = 0, wait_viol = 0, early_ack = 0, mode_viol = 0, val_viol = 0;
    int          cnt = 0;
    logic        prev_req = 1'b0;
    logic        saw_rdy = 1'b0, saw_ovr = 1'b0, saw_ack = 1'b0;
    logic [6:0]  m_addr;
    logic [1:0]  m_be;
    logic        m_we;
    logic [15:0] m_wd;

    initial for (int i = 0; i < 128; i++) mem[i] = 16'h0000;

    always @(negedge clk) begin
        if (rst) begin
            loc_ready = 1'b0;
            cnt = 0;
            prev_req = 1'b0;
        end else begin
            if (req0 && !prev_req) begin
                req_cnt++;
                m_addr = la0; m_be = be0; m_we = we0; m_wd = wd0;
            end
            prev_req = req0;
            if (req0 && !bus_as_n && !rdy0) wait_viol++;
            if (req1 && ack1) early_ack++;
            if (ack0 || ovr0 || rdy1) mode_viol++;
            if (av0 || av1 || rv0 || rv1 || ov0 || ov1) val_viol++;
            if (rdy0) saw_rdy = 1'b1;
            if (ovr1) saw_ovr = 1'b1;
            if (ack1) saw_ack = 1'b1;
            if (req0 && !loc_ready) begin
                if (cnt == LAT) begin
                    if (we0) begin
                        if (be0[0]) mem[la0][7:0]  = wd0[7:0];
                        if (be0[1]) mem[la0][15:8] = wd0[15:8];
                    end
                    loc_rdata = mem[la0];
                    loc_ready = 1'b1;
                    cnt = 0;
                end else begin
                    cnt++;
                end
            end else begin
                loc_ready = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic release_bus();
        @(negedge clk);
        bus_as_n = 1'b1;
        ds_n = 2'b11;
        #1;
        chk(!(ack0 || rdy0 || ovr0 || doe0 || ack1 || rdy1 || ovr1 || doe1), "R8",
            "outputs released with strobe", {ack1, ovr1, rdy0, doe0, doe1}, 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_ack(output bit got, output logic d0, output logic [15:0] rd0);
        got = 1'b0; d0 = 1'b0; rd0 = '0;
        for (int k = 0; k < 30 && !got; k++) begin
            @(negedge clk);
            if (ack1) begin
                got = 1'b1; d0 = doe0; rd0 = rdata0;
            end
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int          r0;
        bit          got;
        logic        d0;
        logic [15:0] rd0;
        r0 = req_cnt;
        saw_rdy = 1'b0; saw_ovr = 1'b0; saw_ack = 1'b0;
        @(negedge clk);
        bus_addr = v.addr[23:1]; bus_rd = v.rd; bus_wdata = v.wd;
        @(negedge clk);
        bus_as_n = 1'b0;
        if (v.rd) ds_n = ~v.be;
        @(negedge clk);
        if (!v.rd) ds_n = ~v.be;
        wait_ack(got, d0, rd0);
        if (v.hit) begin
            chk(got, "R7", $sformatf("own ack vec %0d", idx), got, 1);
            chk(req_cnt - r0 == 1, "R2", $sformatf("request count vec %0d", idx), req_cnt - r0, 1);
            chk(m_addr == v.addr[7:1], "R3", $sformatf("word offset vec %0d", idx), m_addr, v.addr[7:1]);
            chk(m_we == !v.rd, "R3", $sformatf("direction vec %0d", idx), m_we, !v.rd);
            chk(m_be == v.be, "R4", $sformatf("byte enables vec %0d", idx), m_be, v.be);
            if (!v.rd)
                chk(m_wd == v.wd, "R3", $sformatf("write data vec %0d", idx), m_wd, v.wd);
            chk(d0 == v.rd, "R5", $sformatf("data enable vec %0d", idx), d0, v.rd);
            if (v.rd)
                chk(rd0 == v.exp, "R5", $sformatf("read data vec %0d", idx), rd0, v.exp);
            chk(saw_rdy, "R6", $sformatf("ready line held vec %0d", idx), saw_rdy, 1);
            chk(saw_ovr, "R7", $sformatf("override held vec %0d", idx), saw_ovr, 1);
        end else begin
            chk(req_cnt == r0, "R2", $sformatf("miss request vec %0d", idx), req_cnt - r0, 0);
            chk(!(saw_rdy || saw_ovr || saw_ack), "R2", $sformatf("miss drives vec %0d", idx),
                {saw_rdy, saw_ovr, saw_ack}, 0);
        end
        release_bus();
    endtask

    initial begin
        #(4 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int          r0;
        bit          got;
        logic        d0;
        logic [15:0] rd0;
        vec_t        vb;

        // R1: hit cycle presented during reset must not leak out
        bus_addr = 23'h100008; bus_rd = 1'b1;
        repeat (2) @(negedge clk);
        bus_as_n = 1'b0; ds_n = 2'b00;
        repeat (4) @(negedge clk);
        chk(!(ack0 || rdy0 || ovr0 || doe0 || ack1 || rdy1 || ovr1 || doe1 || req0 || req1),
            "R1", "outputs in reset", {ovr1, rdy0, req0}, 0);
        bus_as_n = 1'b1; ds_n = 2'b11;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!(ack1 || rdy0 || ovr1 || req0), "R1", "outputs after reset", {ack1, rdy0, ovr1, req0}, 0);
        chk(!(av0 || av1 || rv0 || rv1 || ov0 || ov1), "R11", "tied values", 0, 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // locked read-modify-write: address strobe held low across two bursts
        vb = '{1'b0, 2'b11, 24'h200020, 16'h00C3, 1'b1, 16'h0000};
        run_vec(vb, 100);
        r0 = req_cnt;
        @(negedge clk);
        bus_addr = 23'h100010; bus_rd = 1'b1;
        @(negedge clk);
        bus_as_n = 1'b0; ds_n = 2'b00;
        wait_ack(got, d0, rd0);
        chk(got && rd0 == 16'h00C3, "R9", "locked read data", rd0, 16'h00C3);
        @(negedge clk);
        ds_n = 2'b11; bus_rd = 1'b0; bus_wdata = 16'h5A00;
        got = 1'b0;
        for (int k = 0; k < 10 && !got; k++) begin
            @(negedge clk);
            if (!ack1) got = 1'b1;
        end
        chk(got, "R7", "ack dropped on strobe negation", got, 1);
        chk(ovr1, "R7", "override kept while locked", ovr1, 1);
        repeat (3) @(negedge clk);
        chk(req_cnt - r0 == 1, "R9", "one access before second burst", req_cnt - r0, 1);
        ds_n = 2'b01;
        wait_ack(got, d0, rd0);
        chk(got && req_cnt - r0 == 2, "R9", "second burst accepted", req_cnt - r0, 2);
        chk(m_we == 1'b1 && m_be == 2'b10, "R9", "second burst write upper", {m_we, m_be}, 3'b110);
        chk(d0 == 1'b0, "R5", "no data enable on locked write", d0, 0);
        repeat (20) @(negedge clk);
        chk(req_cnt - r0 == 2, "R10", "held strobes start one access", req_cnt - r0, 2);
        release_bus();
        vb = '{1'b1, 2'b11, 24'h200020, 16'h0000, 1'b1, 16'h5AC3};
        run_vec(vb, 101);

        chk(wait_viol == 0, "R6", "ready line low while pending", wait_viol, 0);
        chk(early_ack == 0, "R7", "no ack while pending", early_ack, 0);
        chk(mode_viol == 0, "R6", "mode exclusive outputs", mode_viol, 0);
        chk(val_viol == 0, "R11", "tied values never high", val_viol, 0);

        summary();
        $finish;
    end

endmodule